// File: doc/BRIEF.md
# Table pointer access unit

This block moves single bytes between a byte-addressed program memory and an 8-bit data latch, steered by a 22-bit pointer. A processor loads the pointer and the latch through a byte-wide register port, then issues commands. A read fetches the addressed byte into the latch. A write copies the latch into one of sixteen holding registers. A commit stores all sixteen holding registers into an aligned 16-byte block. An erase sets an aligned 64-byte block to 0xFF.

Reads and writes apply one of four pointer updates, and these act on the low 21 bits only. The top bit of the pointer selects a second, small address space for identification and configuration bytes, and arithmetic never changes it. Each operation looks at a different slice of the pointer: a read uses the whole pointer, a write uses the four lowest bits, a commit uses the bits above them, and an erase uses the bits from 6 upwards. A small internal memory array stands in for the program store, so the block can be tested on its own. Commit and erase keep the unit busy for a fixed number of cycles. While it is busy, commands are dropped.

Top module: `tpu_access_unit`

## Requirements
- R1: After reset the pointer is 0, the latch is 0, busy is low, all sixteen holding registers hold 0xFF, and every memory byte in both spaces reads as 0xFF.
- R2: A register write stores reg_wdata into a target chosen by reg_sel: 0 sets pointer bits 7:0, 1 sets bits 15:8, 2 sets bits 21:16 from reg_wdata[5:0], and 3 sets the latch. A command presented in the same cycle as a register write is ignored.
- R3: cmd_mode selects the pointer update for reads and writes: 0 keeps the pointer, 1 increments it after the access, 2 decrements it after the access, and 3 increments it before the access. In mode 3 the access uses the new pointer. In modes 0 to 2 it uses the old pointer. The opcodes on cmd_op are 0 read, 1 write, 2 commit and 3 erase.
- R4: Increment and decrement act on pointer bits 20:0 and wrap modulo 2^21. For example, 0 decremented gives 0x1FFFFF. Bit 21 is never changed by them.
- R5: A read loads the latch with the byte at the access address and holds busy high for exactly one cycle. The latch is valid once busy falls. With bit 21 clear, the address selects one of 2^MAIN_AW main bytes by bits MAIN_AW-1:0. With bit 21 set, it selects one of 2^CFG_AW configuration bytes by bits CFG_AW-1:0. Higher bits alias.
- R6: A write copies the latch into the holding register numbered by access-address bits 3:0. Memory does not change until a commit.
- R7: A commit stores holding register i at offset i of the 16-byte block chosen by pointer bits 21:4. The holding registers then return to 0xFF. The commit leaves the pointer unchanged whatever the mode.
- R8: An erase sets every byte of the 64-byte block chosen by pointer bits 21:6 to 0xFF. Pointer bits 5:0 have no effect, and the pointer is unchanged.
- R9: Commit and erase hold busy high for BUSY_CYCLES cycles after acceptance. A command that arrives while busy is high changes nothing: not the pointer, the latch, the holding registers or the memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register target: 0 low, 1 high, 2 upper, 3 latch |
| reg_wdata | input | 8 | Register write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 read, 1 write, 2 commit, 3 erase |
| cmd_mode | input | 2 | Pointer update: 0 keep, 1 post-inc, 2 post-dec, 3 pre-inc |
| ptr_o | output | 22 | Current pointer |
| latch_o | output | 8 | Current latch value |
| busy_o | output | 1 | High while a read result or a block operation is pending |

## Verification
The assertions assume that cmd_op and cmd_mode carry known values whenever cmd_valid is high. They also assume that reset is applied before the first command, so that the pointer history they compare against is defined. The pointer-step properties are gated on a register write being absent, because a register write wins over the command in that cycle. The bench changes inputs only on falling edges and holds a command for a single cycle. The exceptions are the deliberate repeats during a busy window and the one deliberate collision with a register write, which exercise exactly those ignore rules.

// File: rtl/tpu_pkg.sv
package tpu_pkg;
    localparam int PTR_W      = 22;
    localparam int SPACE_BIT  = 21;
    localparam int HOLD_BYTES = 16;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_COMMIT = 2'd2,
        OP_ERASE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PM_KEEP     = 2'd0,
        PM_POST_INC = 2'd1,
        PM_POST_DEC = 2'd2,
        PM_PRE_INC  = 2'd3
    } ptr_mode_e;

    typedef enum logic [1:0] {
        RS_LOW   = 2'd0,
        RS_HIGH  = 2'd1,
        RS_UPPER = 2'd2,
        RS_LATCH = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tpu_ptr_step.sv
module tpu_ptr_step
    import tpu_pkg::*;
(
    input  logic [PTR_W-1:0] ptr_i,
    input  logic [1:0]       mode_i,
    output logic [PTR_W-1:0] acc_o,
    output logic [PTR_W-1:0] next_o
);
    localparam logic [SPACE_BIT-1:0] ONE = 1;

    logic [SPACE_BIT-1:0] low_inc;
    logic [SPACE_BIT-1:0] low_dec;

    always_comb begin
        low_inc = ptr_i[SPACE_BIT-1:0] + ONE;
        low_dec = ptr_i[SPACE_BIT-1:0] - ONE;
        acc_o   = ptr_i;
        next_o  = ptr_i;
        case (ptr_mode_e'(mode_i))
            PM_POST_INC: next_o = {ptr_i[SPACE_BIT], low_inc};
            PM_POST_DEC: next_o = {ptr_i[SPACE_BIT], low_dec};
            PM_PRE_INC: begin
                next_o = {ptr_i[SPACE_BIT], low_inc};
                acc_o  = {ptr_i[SPACE_BIT], low_inc};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tpu_mem.sv
module tpu_mem
    import tpu_pkg::*;
#(
    parameter int MAIN_AW = 8,
    parameter int CFG_AW  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_en,
    input  logic [PTR_W-1:0]        rd_addr,
    output logic [7:0]              rd_data_o,
    input  logic                    blk_wr_en,
    input  logic                    blk_er_en,
    input  logic [PTR_W-1:0]        op_addr,
    input  logic [HOLD_BYTES*8-1:0] blk_data_i
);
    localparam int MAIN_BYTES = 1 << MAIN_AW;
    localparam int CFG_BYTES  = 1 << CFG_AW;
    localparam int TOTAL      = MAIN_BYTES + CFG_BYTES;
    localparam int IW         = $clog2(TOTAL);

    function automatic logic [IW-1:0] slot(input logic [PTR_W-1:0] a);
        if (a[SPACE_BIT]) slot = IW'(MAIN_BYTES) + IW'(a[CFG_AW-1:0]);
        else              slot = IW'(a[MAIN_AW-1:0]);
    endfunction

    function automatic logic [PTR_W-1:0] canon(input logic [PTR_W-1:0] a);
        canon = '0;
        canon[SPACE_BIT] = a[SPACE_BIT];
        if (a[SPACE_BIT]) canon[CFG_AW-1:0]  = a[CFG_AW-1:0];
        else              canon[MAIN_AW-1:0] = a[MAIN_AW-1:0];
    endfunction

    function automatic logic [PTR_W-1:0] home(input int i);
        if (i < MAIN_BYTES) home = PTR_W'(i);
        else                home = PTR_W'(i - MAIN_BYTES) | (PTR_W'(1) << SPACE_BIT);
    endfunction

    logic [7:0]       mem_q [TOTAL];
    logic [7:0]       mem_d [TOTAL];
    logic [7:0]       rd_q, rd_d;
    logic [PTR_W-1:0] op_c;
    logic             er_hit [TOTAL];
    logic             wr_hit [TOTAL];
    logic [3:0]       sub    [TOTAL];

    assign op_c = canon(op_addr);

    for (genvar g = 0; g < TOTAL; g++) begin : g_byte
        logic [PTR_W-1:0] hm;
        assign hm        = home(g);
        assign er_hit[g] = blk_er_en && (hm[PTR_W-1:6] == op_c[PTR_W-1:6]);
        assign wr_hit[g] = blk_wr_en && (hm[PTR_W-1:4] == op_c[PTR_W-1:4]);
        assign sub[g]    = hm[3:0];
    end

    always_comb begin
        mem_d = mem_q;
        rd_d  = rd_q;
        if (rd_en) rd_d = mem_q[slot(rd_addr)];
        for (int i = 0; i < TOTAL; i++) begin
            if (wr_hit[i])      mem_d[i] = blk_data_i[{sub[i], 3'b000} +: 8];
            else if (er_hit[i]) mem_d[i] = 8'hFF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL; i++) mem_q[i] <= 8'hFF;
            rd_q <= 8'h00;
        end else begin
            mem_q <= mem_d;
            rd_q  <= rd_d;
        end
    end

    assign rd_data_o = rd_q;

    logic unused_addr_bits;
    assign unused_addr_bits = ^{rd_addr, op_addr, op_c};

    // R8: the addressed byte is blank after an erase
    p_erase_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        blk_er_en |=> mem_q[slot($past(op_addr))] == 8'hFF);

    // R7: the addressed byte takes its holding register after a commit
    p_commit_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        blk_wr_en |=> mem_q[slot($past(op_addr))] ==
                      $past(blk_data_i[{op_addr[3:0], 3'b000} +: 8]));

    // R9: only one block operation is started at a time
    p_one_block_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(blk_wr_en && blk_er_en));
endmodule

// File: rtl/tpu_access_unit.sv
module tpu_access_unit
    import tpu_pkg::*;
#(
    parameter int MAIN_AW     = 8,
    parameter int CFG_AW      = 4,
    parameter int BUSY_CYCLES = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [7:0]  reg_wdata,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [1:0]  cmd_mode,
    output logic [21:0] ptr_o,
    output logic [7:0]  latch_o,
    output logic        busy_o
);
    localparam int CW     = $clog2(BUSY_CYCLES + 1);
    localparam int HOLD_W = HOLD_BYTES * 8;

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [7:0]        latch;
        logic [HOLD_W-1:0] hold;
        logic              rd_pend;
        logic [CW-1:0]     cnt;
    } unit_st_t;

    unit_st_t         st_d, st_q;
    logic             accept;
    op_e              op;
    logic [PTR_W-1:0] acc_addr, next_ptr;
    logic [7:0]       mem_rdata;
    logic             rd_en, wr_en, er_en;

    assign op     = op_e'(cmd_op);
    assign busy_o = st_q.rd_pend || (st_q.cnt != '0);
    assign accept = cmd_valid && !busy_o && !reg_we;

    tpu_ptr_step u_step (
        .ptr_i  (st_q.ptr),
        .mode_i (cmd_mode),
        .acc_o  (acc_addr),
        .next_o (next_ptr)
    );

    tpu_mem #(.MAIN_AW(MAIN_AW), .CFG_AW(CFG_AW)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .rd_addr    (acc_addr),
        .rd_data_o  (mem_rdata),
        .blk_wr_en  (wr_en),
        .blk_er_en  (er_en),
        .op_addr    (st_q.ptr),
        .blk_data_i (st_q.hold)
    );

    always_comb begin
        st_d  = st_q;
        rd_en = 1'b0;
        wr_en = 1'b0;
        er_en = 1'b0;
        if (st_q.cnt != '0) st_d.cnt = st_q.cnt - CW'(1);
        if (st_q.rd_pend) begin
            st_d.latch   = mem_rdata;
            st_d.rd_pend = 1'b0;
        end
        if (accept) begin
            case (op)
                OP_READ: begin
                    rd_en        = 1'b1;
                    st_d.rd_pend = 1'b1;
                    st_d.ptr     = next_ptr;
                end
                OP_WRITE: begin
                    st_d.hold[{acc_addr[3:0], 3'b000} +: 8] = st_q.latch;
                    st_d.ptr = next_ptr;
                end
                OP_COMMIT: begin
                    wr_en     = 1'b1;
                    st_d.hold = '1;
                    st_d.cnt  = CW'(BUSY_CYCLES);
                end
                default: begin
                    er_en    = 1'b1;
                    st_d.cnt = CW'(BUSY_CYCLES);
                end
            endcase
        end
        if (reg_we) begin
            case (reg_sel_e'(reg_sel))
                RS_LOW:   st_d.ptr[7:0]   = reg_wdata;
                RS_HIGH:  st_d.ptr[15:8]  = reg_wdata;
                RS_UPPER: st_d.ptr[21:16] = reg_wdata[5:0];
                default:  st_d.latch      = reg_wdata;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr     <= '0;
            st_q.latch   <= '0;
            st_q.hold    <= '1;
            st_q.rd_pend <= 1'b0;
            st_q.cnt     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o   = st_q.ptr;
    assign latch_o = st_q.latch;

    // R3: post-increment steps the low 21 bits by one
    p_post_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !cmd_op[1] && cmd_mode == PM_POST_INC
        |=> ptr_o[20:0] == $past(ptr_o[20:0]) + 21'd1);

    // R4: post-decrement wraps in 21 bits and keeps bit 21
    p_post_dec_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !cmd_op[1] && cmd_mode == PM_POST_DEC
        |=> ptr_o == {$past(ptr_o[21]), $past(ptr_o[20:0]) - 21'd1});

    // R4: the space-select bit survives every read or write
    p_space_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !cmd_op[1] |=> ptr_o[21] == $past(ptr_o[21]));

    // R5: a read is busy for exactly one cycle
    p_read_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept && op == OP_READ |=> busy_o ##1 !busy_o);

    // R7: holding registers are blank after a commit
    p_hold_refill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept && op == OP_COMMIT |=> st_q.hold == '1);

    // R9: block operations raise busy
    p_block_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cmd_op[1] |=> busy_o);

    // R9: nothing moves the pointer while busy except a register write
    p_busy_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !reg_we |=> $stable(ptr_o));
endmodule

// File: tb/test_tpu_access_unit.sv
module test_tpu_access_unit;
    localparam int CLK_PERIOD = 10;
    localparam int MAIN_AW    = 8;
    localparam int CFG_AW     = 4;
    localparam int BUSY       = 5;
    localparam int MAIN_BYTES = 1 << MAIN_AW;
    localparam int CFG_BYTES  = 1 << CFG_AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [1:0]  cmd_mode = '0;
    logic [21:0] ptr_o;
    logic [7:0]  latch_o;
    logic        busy_o;

    int checks = 0;
    int errors = 0;

    logic [7:0]  m_mem [MAIN_BYTES + CFG_BYTES];
    logic [7:0]  m_hold [16];
    logic [21:0] m_ptr;
    logic [7:0]  m_latch;

    tpu_access_unit #(.MAIN_AW(MAIN_AW), .CFG_AW(CFG_AW), .BUSY_CYCLES(BUSY))
    i_tpu_access_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_mode(cmd_mode), .ptr_o(ptr_o), .latch_o(latch_o), .busy_o(busy_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int midx(input logic [21:0] a);
        if (a[21]) return MAIN_BYTES + int'(a[CFG_AW-1:0]);
        return int'(a[MAIN_AW-1:0]);
    endfunction

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_reg(input logic [1:0] sel, input logic [7:0] val);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
        case (sel)
            2'd0: m_ptr[7:0]   = val;
            2'd1: m_ptr[15:8]  = val;
            2'd2: m_ptr[21:16] = val[5:0];
            default: m_latch   = val;
        endcase
    endtask

    task automatic set_ptr(input logic [21:0] a);
        set_reg(2'd0, a[7:0]);
        set_reg(2'd1, a[15:8]);
        set_reg(2'd2, {2'b00, a[21:16]});
    endtask

    // junk: cycles during busy in which a read/post-inc stays asserted (R9)
    task automatic run_cmd(input logic [1:0] op, input logic [1:0] mode, input int junk);
        logic [21:0] acc, nxt;
        int n, exp_busy;
        acc = m_ptr; nxt = m_ptr;
        case (mode)
            2'd1: nxt = {m_ptr[21], m_ptr[20:0] + 21'd1};
            2'd2: nxt = {m_ptr[21], m_ptr[20:0] - 21'd1};
            2'd3: begin nxt = {m_ptr[21], m_ptr[20:0] + 21'd1}; acc = nxt; end
            default: ;
        endcase
        case (op)
            2'd0: begin m_latch = m_mem[midx(acc)]; m_ptr = nxt; exp_busy = 1; end
            2'd1: begin m_hold[acc[3:0]] = m_latch; m_ptr = nxt; exp_busy = 0; end
            2'd2: begin
                for (int i = 0; i < 16; i++) m_mem[midx({m_ptr[21:4], 4'(i)})] = m_hold[i];
                for (int i = 0; i < 16; i++) m_hold[i] = 8'hFF;
                exp_busy = BUSY;
            end
            default: begin
                for (int i = 0; i < 64; i++) m_mem[midx({m_ptr[21:6], 6'(i)})] = 8'hFF;
                exp_busy = BUSY;
            end
        endcase
        cmd_valid = 1'b1; cmd_op = op; cmd_mode = mode;
        @(negedge clk);
        if (junk > 0) begin cmd_op = 2'd0; cmd_mode = 2'd1; end
        n = 0;
        while (busy_o && n < 100) begin
            if (n >= junk) cmd_valid = 1'b0;
            n++;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        check("R9 busy length", n, exp_busy);
        check(op == 2'd3 ? "R8 pointer" : op == 2'd2 ? "R7 pointer" : "R3 pointer", ptr_o, m_ptr);
        check(op == 2'd0 ? "R5 latch" : "R6 latch", latch_o, m_latch);
    endtask

    task automatic sweep_main();
        set_ptr(22'h0);
        for (int a = 0; a < MAIN_BYTES; a++) run_cmd(2'd0, 2'd1, 0);
    endtask

    task automatic sweep_cfg();
        set_ptr(22'h20000F);
        for (int a = 0; a < CFG_BYTES; a++) run_cmd(2'd0, 2'd2, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < MAIN_BYTES + CFG_BYTES; i++) m_mem[i] = 8'hFF;
        for (int i = 0; i < 16; i++) m_hold[i] = 8'hFF;
        m_ptr = '0; m_latch = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pointer", ptr_o, 0);
        check("R1 latch", latch_o, 0);
        check("R1 busy", busy_o, 0);
        sweep_main();
        sweep_cfg();
        // R1 holding registers blank: commit without writes
        set_ptr(22'h30);
        run_cmd(2'd2, 2'd0, 0);
        set_ptr(22'h30);
        run_cmd(2'd0, 2'd0, 0);

        // R2 register targets
        set_reg(2'd2, 8'hFF);
        check("R2 upper", ptr_o, 22'h3F0030);
        set_reg(2'd1, 8'hA5);
        set_reg(2'd0, 8'h3C);
        check("R2 high low", ptr_o, 22'h3FA53C);
        set_reg(2'd3, 8'h96);
        check("R2 latch", latch_o, 8'h96);

        // R6 R7 fill main memory, varying the pointer mode per block
        for (int b = 0; b < 16; b++) begin
            int m;
            m = b % 4;
            if (m == 1 || m == 3) set_ptr(22'(b * 16 - 1));
            else if (m == 2)      set_ptr(22'(b * 16 + 15));
            else                  set_ptr(22'(b * 16));
            for (int i = 0; i < 16; i++) begin
                int off;
                off = (m == 2) ? 15 - i : i;
                set_reg(2'd3, pat(b * 16 + off));
                run_cmd(2'd1, (m == 1 || m == 3) ? 2'd3 : (m == 2) ? 2'd2 : 2'd1, 0);
            end
            set_ptr(22'(b * 16 + (b % 16)));
            run_cmd(2'd2, 2'd1, 0);
        end
        set_ptr(22'h200000);
        for (int i = 0; i < 16; i++) begin
            set_reg(2'd3, pat(1000 + i));
            run_cmd(2'd1, 2'd1, 0);
        end
        set_ptr(22'h200007);
        run_cmd(2'd2, 2'd0, 0);
        sweep_main();
        sweep_cfg();

        // R6 write alone leaves memory unchanged
        set_reg(2'd3, 8'h5A);
        set_ptr(22'h10);
        run_cmd(2'd1, 2'd0, 0);
        run_cmd(2'd0, 2'd0, 0);
        check("R6 memory untouched", latch_o, pat(16));
        // R7 holding refilled after commit: only offset 0 carries data
        set_ptr(22'h84);
        run_cmd(2'd2, 2'd0, 0);
        set_ptr(22'h80);
        for (int i = 0; i < 16; i++) run_cmd(2'd0, 2'd1, 0);

        // R4 wrap cases
        set_ptr(22'h0);
        run_cmd(2'd0, 2'd2, 0);
        check("R4 dec wrap", ptr_o, 22'h1FFFFF);
        set_ptr(22'h200000);
        run_cmd(2'd0, 2'd2, 0);
        check("R4 dec keeps bit21", ptr_o, 22'h3FFFFF);
        run_cmd(2'd0, 2'd3, 0);
        check("R4 pre-inc wrap", ptr_o, 22'h200000);
        check("R3 pre-inc reads new address", latch_o, pat(1000));
        set_ptr(22'h1FFFFF);
        run_cmd(2'd1, 2'd1, 0);
        check("R4 inc wrap", ptr_o, 22'h0);

        // R2 command colliding with a register write is dropped
        set_ptr(22'h20);
        run_cmd(2'd0, 2'd0, 0);
        reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h44;
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_mode = 2'd1;
        @(negedge clk);
        reg_we = 1'b0; cmd_valid = 1'b0;
        m_ptr[7:0] = 8'h44;
        check("R2 collision busy", busy_o, 0);
        @(negedge clk);
        check("R2 collision pointer", ptr_o, 22'h44);
        check("R2 collision latch", latch_o, m_latch);

        // R8 R9 erase with commands repeated while busy
        set_ptr(22'h7B);
        run_cmd(2'd3, 2'd1, 3);
        set_ptr(22'h200023);
        run_cmd(2'd3, 2'd0, 2);
        set_ptr(22'hC5);
        run_cmd(2'd2, 2'd3, 4);
        sweep_main();
        sweep_cfg();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule